// File: doc/BRIEF.md
# Word-Parallel Serial Link Datapath with Loopback Control

This block converts 16-bit parallel words to a serial bit stream and back. The transmit side loads a word once every sixteen bit times and shifts it out most significant bit first. The receive side gathers sixteen serial bits into a word and presents that word together with a word clock. Word boundaries run freely from reset, and no framing search is done.

The bench supplies two bit clocks: a reference bit clock and a recovered bit clock. A loop-timing control picks which of the two drives the transmit shifter. Three loopback controls choose where the serial output and the receive path take their data from:

- **Retimed line loopback** sends the received stream back out after one recovered-clock register.
- **Raw line loopback** passes the received stream straight to the output.
- **Equipment loopback** feeds the transmit stream into the receive path in place of the line input.

A signal-detect input forces the line input to zero when the line is lost, except while equipment loopback is active.

The control is organised as two small enumerated state sets:

- **Shifter phase**, in each shifter. `PH_SHIFT` moves one bit per edge. `PH_LOAD` is the last bit time of a word. In the transmitter it loads the next word, and in the receiver it captures the finished word. The phase goes from `PH_SHIFT` to `PH_LOAD` when the bit counter reaches its last count, and returns to `PH_SHIFT` on the next edge.
- **Output path**, decoded from the loop controls. `PATH_SHIFTER` is normal transmit, `PATH_RAW` is unretimed loopback and `PATH_RETIMED` is retimed loopback. The decode is combinational, so the path follows the controls directly.

Top module: `serdes_loop`

## Requirements
- R1: The transmitter samples `tx_word` on the transmit bit-clock edge where `tx_word_clk` falls. On that edge and the 15 edges that follow, `tx_serial` presents bits 15 down to 0 in turn.
- R2: The first received bit of a word lands in bit 15 of `rx_word` and the sixteenth lands in bit 0. After reset, the first recovered-clock edge samples the first bit of a word.
- R3: `rx_word_clk` is the recovered clock divided by 16: it is low for counts 0 to 7 and high for counts 8 to 15. `rx_word` changes only on the recovered-clock edge where `rx_word_clk` falls.
- R4: With `line_loop` high, `tx_serial` equals the `rx_serial` value sampled at the previous recovered-clock edge. The receive words are still assembled from `rx_serial`.
- R5: With `line_loop` low and `raw_loop` high, `tx_serial` follows `rx_serial` with no register in between.
- R6: With both `line_loop` and `raw_loop` high, the retimed path of R4 is used.
- R7: With `line_loop` and `raw_loop` both low, `tx_serial` carries the transmit shifter output.
- R8: With `diag_loop` high, the receive path takes the transmit serial stream in place of `rx_serial`, and `sig_det` has no effect.
- R9: With `diag_loop` low and `sig_det` low, every received bit is taken as 0.
- R10: With `loop_time` high, the recovered clock drives the transmit shifter. With `loop_time` low, the reference clock drives it.
- R11: `tx_word_clk` is the selected transmit bit clock divided by 16: it is low for counts 0 to 7 and high for counts 8 to 15.
- R12: While `rst_n` is low, `rx_word`, `rx_word_clk` and `tx_word_clk` are 0. In the normal path `tx_serial` is also 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference bit clock |
| rec_clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_loop | input | 1 | Retimed line loopback enable |
| raw_loop | input | 1 | Unretimed line loopback enable |
| diag_loop | input | 1 | Equipment loopback enable |
| loop_time | input | 1 | Use the recovered clock for transmit |
| sig_det | input | 1 | Line signal present |
| tx_word | input | 16 | Parallel word to transmit |
| tx_word_clk | output | 1 | Transmit word clock |
| tx_serial | output | 1 | Serial output |
| rx_serial | input | 1 | Serial line input |
| rx_word | output | 16 | Received parallel word |
| rx_word_clk | output | 1 | Receive word clock |

## Verification
Random words are pushed through each path:

- The transmit-only run separates bit order from word-load timing.
- Line-input runs in retimed, raw and both-enabled modes tell the one-register path from the direct path and show which one has priority.
- The equipment loopback run holds `sig_det` low and `rx_serial` high. A stuck-at-ones word or zero words would then expose leakage from the line input or from signal detect.

Word-clock edge counts, with the reference clock stopped and running, show which clock drives the transmitter.

// File: rtl/sd_pkg.sv
package sd_pkg;
    typedef enum logic {
        PH_SHIFT,
        PH_LOAD
    } shift_phase_e;

    typedef enum logic [1:0] {
        PATH_SHIFTER,
        PATH_RAW,
        PATH_RETIMED
    } out_path_e;
endpackage

// File: rtl/sd_tx_shift.sv
module sd_tx_shift
    import sd_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] word_in,
    output logic         bit_out,
    output logic         word_clk
);
    localparam int          CW    = $clog2(W);
    localparam int unsigned LASTI = W - 1;
    localparam logic [CW-1:0] LAST = LASTI[CW-1:0];

    logic [CW-1:0] cnt;
    logic [W-1:0]  sh;
    shift_phase_e  phase;

    always_comb phase = (cnt == LAST) ? PH_LOAD : PH_SHIFT;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            sh  <= '0;
        end else begin
            unique case (phase)
                PH_LOAD: begin
                    cnt <= '0;
                    sh  <= word_in;
                end
                PH_SHIFT: begin
                    cnt <= cnt + 1'b1;
                    sh  <= {sh[W-2:0], 1'b0};
                end
            endcase
        end
    end

    always_comb begin
        bit_out  = sh[W-1];
        word_clk = cnt[CW-1];
    end

    // R1: the top bit of the sampled word appears right after the load edge
    a_r1_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LOAD) |=> (bit_out == $past(word_in[W-1])));

    // R11: the word clock falls only where a new word has just been taken
    a_r11_fall_at_load: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(word_clk) |-> (bit_out == $past(word_in[W-1])));
endmodule

// File: rtl/sd_rx_shift.sv
module sd_rx_shift
    import sd_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_in,
    output logic [W-1:0] word_out,
    output logic         word_clk
);
    localparam int          CW    = $clog2(W);
    localparam int unsigned LASTI = W - 1;
    localparam logic [CW-1:0] LAST = LASTI[CW-1:0];

    logic [CW-1:0] cnt;
    logic [W-2:0]  sh;
    shift_phase_e  phase;

    always_comb phase = (cnt == LAST) ? PH_LOAD : PH_SHIFT;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            sh       <= '0;
            word_out <= '0;
        end else begin
            unique case (phase)
                PH_LOAD: begin
                    cnt      <= '0;
                    word_out <= {sh, bit_in};
                end
                PH_SHIFT: begin
                    cnt <= cnt + 1'b1;
                end
            endcase
            sh <= {sh[W-3:0], bit_in};
        end
    end

    always_comb word_clk = cnt[CW-1];

    // R3: the word output moves only at the falling word-clock edge
    a_r3_word_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(word_clk) |-> $stable(word_out));

    // R2: the last bit sampled lands in the least significant position
    a_r2_last_bit_lsb: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(word_clk) |-> (word_out[0] == $past(bit_in)));
endmodule

// File: rtl/sd_path_sel.sv
module sd_path_sel
    import sd_pkg::*;
(
    input  logic ref_clk,
    input  logic rec_clk,
    input  logic rst_n,
    input  logic line_loop,
    input  logic raw_loop,
    input  logic diag_loop,
    input  logic loop_time,
    input  logic sig_det,
    input  logic rx_in,
    input  logic shift_bit,
    output logic tx_clk,
    output logic ser_out,
    output logic rx_src
);
    out_path_e path;
    logic      retime_q;

    assign tx_clk = loop_time ? rec_clk : ref_clk;

    always_comb begin
        if (line_loop)      path = PATH_RETIMED;
        else if (raw_loop)  path = PATH_RAW;
        else                path = PATH_SHIFTER;
    end

    always_ff @(posedge rec_clk or negedge rst_n) begin
        if (!rst_n) retime_q <= 1'b0;
        else        retime_q <= rx_in;
    end

    always_comb begin
        unique case (path)
            PATH_RETIMED: ser_out = retime_q;
            PATH_RAW:     ser_out = rx_in;
            default:      ser_out = shift_bit;
        endcase
    end

    always_comb rx_src = diag_loop ? shift_bit : (rx_in & sig_det);

    // R4 / R6: the retimed path repeats the line bit one recovered edge later
    a_r4_retimed_loop: assert property (@(posedge rec_clk) disable iff (!rst_n)
        (line_loop && $past(rst_n)) |-> (ser_out == $past(rx_in)));
endmodule

// File: rtl/serdes_loop.sv
module serdes_loop #(
    parameter int W = 16
) (
    input  logic         ref_clk,
    input  logic         rec_clk,
    input  logic         rst_n,
    input  logic         line_loop,
    input  logic         raw_loop,
    input  logic         diag_loop,
    input  logic         loop_time,
    input  logic         sig_det,
    input  logic [W-1:0] tx_word,
    output logic         tx_word_clk,
    output logic         tx_serial,
    input  logic         rx_serial,
    output logic [W-1:0] rx_word,
    output logic         rx_word_clk
);
    logic tx_clk;
    logic shift_bit;
    logic rx_src;

    sd_path_sel u_path (
        .ref_clk   (ref_clk),
        .rec_clk   (rec_clk),
        .rst_n     (rst_n),
        .line_loop (line_loop),
        .raw_loop  (raw_loop),
        .diag_loop (diag_loop),
        .loop_time (loop_time),
        .sig_det   (sig_det),
        .rx_in     (rx_serial),
        .shift_bit (shift_bit),
        .tx_clk    (tx_clk),
        .ser_out   (tx_serial),
        .rx_src    (rx_src)
    );

    sd_tx_shift #(.W(W)) u_tx (
        .clk      (tx_clk),
        .rst_n    (rst_n),
        .word_in  (tx_word),
        .bit_out  (shift_bit),
        .word_clk (tx_word_clk)
    );

    sd_rx_shift #(.W(W)) u_rx (
        .clk      (rec_clk),
        .rst_n    (rst_n),
        .bit_in   (rx_src),
        .word_out (rx_word),
        .word_clk (rx_word_clk)
    );

    // R8: with equipment loopback and loop timing, a received word's last
    // bit is the bit the transmitter presented on the previous edge
    a_r8_diag_source: assert property (@(posedge rec_clk) disable iff (!rst_n)
        ($fell(rx_word_clk) && $past(diag_loop) && $past(loop_time))
        |-> (rx_word[0] == $past(tx_serial) || line_loop || raw_loop));
endmodule

// File: tb/serdes_loop_bench.sv
module serdes_loop_bench;
    localparam int W = 16;

    logic         ref_clk = 1'b0;
    logic         rec_clk = 1'b0;
    logic         ref_run = 1'b1;
    logic         rst_n = 1'b0;
    logic         line_loop = 1'b0, raw_loop = 1'b0, diag_loop = 1'b0;
    logic         loop_time = 1'b0, sig_det = 1'b1;
    logic [W-1:0] tx_word = '0;
    logic         tx_word_clk, tx_serial;
    logic         rx_serial = 1'b0;
    logic [W-1:0] rx_word;
    logic         rx_word_clk;

    int checks = 0;
    int errors = 0;
    int rises  = 0;

    always #4 rec_clk = ~rec_clk;               // 125 MHz recovered clock
    always #5 if (ref_run) ref_clk = ~ref_clk;  // reference clock, gated

    always @(posedge tx_word_clk) rises++;

    serdes_loop #(.W(W)) u_serdes_loop (
        .ref_clk(ref_clk), .rec_clk(rec_clk), .rst_n(rst_n),
        .line_loop(line_loop), .raw_loop(raw_loop), .diag_loop(diag_loop),
        .loop_time(loop_time), .sig_det(sig_det), .tx_word(tx_word),
        .tx_word_clk(tx_word_clk), .tx_serial(tx_serial), .rx_serial(rx_serial),
        .rx_word(rx_word), .rx_word_clk(rx_word_clk)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge rec_clk);
        rst_n = 1'b1;
    endtask

    // Expected retimed / raw output: the line bit itself
    function automatic logic exp_loop_bit(input logic [W-1:0] w, input int b);
        return w[b];
    endfunction

    // Drive random words on rx_serial, MSB first; chk: 0 none, 1 retimed, 2 raw
    task automatic recv_words(input int n, input int chk, input logic squelch, input string tag);
        logic [W-1:0] prev = '0;
        for (int k = 0; k < n; k++) begin
            logic [W-1:0] w = W'($urandom);
            if (k == 0) w = (chk == 0) ? 16'hFFFF : 16'h8001;
            for (int b = W - 1; b >= 0; b--) begin
                rx_serial = w[b];
                if (chk == 2) begin
                    #1;
                    check(tx_serial == exp_loop_bit(w, b), "R5 raw loop", tx_serial, w[b]);
                end
                @(negedge rec_clk);
                if (chk == 1)
                    check(tx_serial == exp_loop_bit(w, b), {tag, " retimed"}, tx_serial, w[b]);
                if (b == 7 && k > 0)
                    check(rx_word == prev, "R3 word held mid-word", rx_word, prev);
            end
            prev = squelch ? '0 : w;
            check(rx_word == prev, {tag, " rx word"}, rx_word, prev);
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));

        // R12: reset state
        repeat (2) @(negedge rec_clk);
        check(rx_word == '0, "R12 rx_word", rx_word, 0);
        check(rx_word_clk == 1'b0 && tx_word_clk == 1'b0, "R12 word clocks",
              {rx_word_clk, tx_word_clk}, 0);
        check(tx_serial == 1'b0, "R12 tx_serial", tx_serial, 0);

        // R1 / R7: normal transmit on the reference clock
        do_reset();
        tx_word = W'($urandom);
        for (int k = 0; k < 6; k++) begin
            logic [W-1:0] cur;
            @(negedge tx_word_clk);
            cur = tx_word;
            tx_word = (k == 2) ? 16'h8000 : W'($urandom);
            for (int j = 0; j < W; j++) begin
                @(negedge ref_clk);
                check(tx_serial == cur[W-1-j], "R1 R7 tx bit order", tx_serial, cur[W-1-j]);
            end
        end

        // R2 / R3: receive path with the line input
        do_reset();
        recv_words(6, 0, 1'b0, "R2");

        // R4: retimed line loopback
        line_loop = 1'b1;
        do_reset();
        recv_words(5, 1, 1'b0, "R4");

        // R6: both loopbacks high, retimed wins
        raw_loop = 1'b1;
        do_reset();
        recv_words(3, 1, 1'b0, "R6");

        // R5: raw loopback only
        line_loop = 1'b0;
        do_reset();
        recv_words(3, 2, 1'b0, "R5");
        raw_loop = 1'b0;

        // R9: signal lost, line input forced to zero
        sig_det = 1'b0;
        do_reset();
        recv_words(3, 0, 1'b1, "R9");

        // R8: equipment loopback with loop timing, sig_det low, line held high
        diag_loop = 1'b1;
        loop_time = 1'b1;
        rx_serial = 1'b1;
        do_reset();
        begin
            logic [W-1:0] loaded;
            tx_word = W'($urandom);
            @(negedge tx_word_clk);
            loaded = tx_word;
            tx_word = 16'h0001;
            for (int k = 0; k < 6; k++) begin
                logic [W-1:0] next;
                @(negedge tx_word_clk);
                next = tx_word;
                @(negedge rec_clk);
                check(rx_word == loaded, "R8 diag loopback word", rx_word, loaded);
                loaded = next;
                tx_word = W'($urandom);
            end
        end
        diag_loop = 1'b0;
        sig_det = 1'b1;

        // R10 / R11: reference stopped, loop timing keeps the transmitter running
        ref_run = 1'b0;
        do_reset();
        rises = 0;
        repeat (160) @(negedge rec_clk);
        check(rises >= 9 && rises <= 11, "R10 R11 loop-timed word clock", rises, 10);

        // R10: reference stopped, no loop timing, transmitter halts
        loop_time = 1'b0;
        do_reset();
        rises = 0;
        repeat (160) @(negedge rec_clk);
        check(rises == 0, "R10 stopped reference", rises, 0);

        // R11: reference running at 10 ns, 16 bits per word clock
        ref_run = 1'b1;
        do_reset();
        rises = 0;
        #1600;
        check(rises >= 9 && rises <= 11, "R11 reference word clock", rises, 10);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule